// File: doc/BRIEF.md
# Domain-Group Access Permission Checker

This block decides whether a transaction on an on-chip interconnect may proceed. Each request names an initiating master, a target slave and whether the access is secure or non-secure. The block resolves the master to one of eight security domains and the slave to one of eight slave groups. It then looks up a 2-bit permission code for that pair, and the selected bit of that code denies the access for its security state. A global bypass lets every request through. Generating the error response for a denied request is left to the surrounding fabric.

Three sets of tables are held in a small register file on a 32-bit word-addressed bus: the master-to-domain map, the slave-to-group map and the permission table. A write takes effect at the clock edge on which `reg_wr_en` is high. Reads are combinational from `reg_addr`.

Requests enter on a valid/ready channel. The result leaves on a second valid/ready channel with one register stage between them. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or is being drained in the same cycle. Once raised, `rsp_valid` and `rsp_allow` stay constant until `rsp_ready` is seen high at a clock edge. A request offered while the output is stalled waits and is not lost.

Top module: `acc_perm_checker`

## Requirements
- R1: After reset, every register reads zero, `rsp_valid` is low, and every request is allowed, because all masters sit in domain 0, all slaves sit in group 0 and every permission code is 00.
- R2: The word address map is as follows. Domain words are at 0 and 1, group words at 16 to 19, permission words at 32 to 35, and the control word at 48, whose bit 0 is the bypass and whose other bits read zero. Mapped words read back the value last written. Writes to any other address are dropped, and reads of any other address return zero.
- R3: Master m takes its domain from domain word m/8, bits [4*(m%8)+3 : 4*(m%8)].
- R4: Slave s takes its group from group word s/5, bits [4*(s%5)+3 : 4*(s%5)]. Bits 31:20 of a group word are stored but never decoded.
- R5: The code for domain d and group g is held in permission word g/2, at bit offset 16*(g%2)+2*d. Its high bit denies non-secure access and its low bit denies secure access. So 00 opens both states, 01 opens non-secure only, 10 opens secure only and 11 closes both.
- R6: A domain or group field holding a value from 8 to 15 is treated as 7.
- R7: A master ID of 16 or more resolves to domain 7. A slave ID of 20 or more resolves to group 7.
- R8: While the bypass bit is set, every accepted request is answered with allow.
- R9: The result of a request is presented on `rsp_valid`/`rsp_allow` in the cycle after acceptance. It is held unchanged while `rsp_ready` is low, and `req_ready` is low during that stall.
- R10: A request accepted on the same edge as a register write is judged by the tables as they were before that write.
- R11: With permission word 0 set to 0xBFFE3FF0, group 0 is open in both states to domains 0, 1 and 7. Group 1 is open only to secure accesses from domains 0 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_master | input | 6 | Initiating master ID |
| req_slave | input | 6 | Target slave ID |
| req_secure | input | 1 | 1 for a secure access |
| rsp_valid | output | 1 | Decision present |
| rsp_ready | input | 1 | Downstream takes the decision |
| rsp_allow | output | 1 | 1 permits the request, 0 denies it |

## Verification
A register write lands at the edge where it is strobed, and read data follow the address within the same cycle. The bench therefore checks a read a moment after changing the address at a falling edge. A decision appears one edge after acceptance. Every request check drives at a falling edge, lets one rising edge pass, and samples `rsp_valid` and `rsp_allow` at the next falling edge, before the following edge can drain them. The stall and same-edge-write cases reuse this one-cycle rule: they hold `rsp_ready` low for several edges, or strobe a write on the accepting edge, and confirm the earlier outcome.

// File: rtl/acc_perm_pkg.sv
package acc_perm_pkg;
  localparam int WORD_W       = 32;
  localparam int FIELD_W      = 4;
  localparam int CODE_W       = 2;
  localparam int IDX_W        = 3;
  localparam int NUM_DOMAINS  = 1 << IDX_W;
  localparam int NUM_GROUPS   = 1 << IDX_W;
  localparam int DOM_PER_WORD = 8;
  localparam int GRP_PER_WORD = 5;
  localparam int LUT_WORDS    = NUM_GROUPS / 2;
  localparam int HALF_W       = WORD_W / 2;
  localparam int ADDR_W       = 6;
  localparam int DOM_BASE     = 0;
  localparam int GRP_BASE     = 16;
  localparam int LUT_BASE     = 32;
  localparam int CTRL_ADDR    = 48;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_DOMAINS - 1);
endpackage

// File: rtl/acc_cfg_regs.sv
module acc_cfg_regs
  import acc_perm_pkg::*;
#(
  parameter int NUM_MASTERS = 16,
  parameter int NUM_SLAVES  = 20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [WORD_W-1:0]               wdata,
  output logic [WORD_W-1:0]               rdata,
  output logic [NUM_MASTERS*FIELD_W-1:0]  dom_fields,
  output logic [NUM_SLAVES*FIELD_W-1:0]   grp_fields,
  output logic [LUT_WORDS*WORD_W-1:0]     lut_flat,
  output logic                            bypass
);
  localparam int DOM_WORDS = (NUM_MASTERS + DOM_PER_WORD - 1) / DOM_PER_WORD;
  localparam int GRP_WORDS = (NUM_SLAVES + GRP_PER_WORD - 1) / GRP_PER_WORD;

  logic [WORD_W-1:0] dom_q [DOM_WORDS];
  logic [WORD_W-1:0] grp_q [GRP_WORDS];
  logic [WORD_W-1:0] lut_q [LUT_WORDS];
  logic              bypass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DOM_WORDS; i++) dom_q[i] <= '0;
      for (int i = 0; i < GRP_WORDS; i++) grp_q[i] <= '0;
      for (int i = 0; i < LUT_WORDS; i++) lut_q[i] <= '0;
      bypass_q <= 1'b0;
    end else if (wr_en) begin
      for (int i = 0; i < DOM_WORDS; i++)
        if (addr == ADDR_W'(DOM_BASE + i)) dom_q[i] <= wdata;
      for (int i = 0; i < GRP_WORDS; i++)
        if (addr == ADDR_W'(GRP_BASE + i)) grp_q[i] <= wdata;
      for (int i = 0; i < LUT_WORDS; i++)
        if (addr == ADDR_W'(LUT_BASE + i)) lut_q[i] <= wdata;
      if (addr == ADDR_W'(CTRL_ADDR)) bypass_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DOM_WORDS; i++)
      if (addr == ADDR_W'(DOM_BASE + i)) rdata = dom_q[i];
    for (int i = 0; i < GRP_WORDS; i++)
      if (addr == ADDR_W'(GRP_BASE + i)) rdata = grp_q[i];
    for (int i = 0; i < LUT_WORDS; i++)
      if (addr == ADDR_W'(LUT_BASE + i)) rdata = lut_q[i];
    if (addr == ADDR_W'(CTRL_ADDR)) rdata = {{(WORD_W-1){1'b0}}, bypass_q};
  end

  // Field extraction: each ID's nibble is pulled out of its packing word.
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_dom
    assign dom_fields[m*FIELD_W +: FIELD_W] =
      dom_q[m / DOM_PER_WORD][(m % DOM_PER_WORD)*FIELD_W +: FIELD_W];
  end
  for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_grp
    assign grp_fields[s*FIELD_W +: FIELD_W] =
      grp_q[s / GRP_PER_WORD][(s % GRP_PER_WORD)*FIELD_W +: FIELD_W];
  end
  for (genvar w = 0; w < LUT_WORDS; w++) begin : g_lut
    assign lut_flat[w*WORD_W +: WORD_W] = lut_q[w];
  end
  assign bypass = bypass_q;

  AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(CTRL_ADDR)) |=> (bypass == $past(wdata[0]))); // R2
endmodule

// File: rtl/acc_id_map.sv
module acc_id_map
  import acc_perm_pkg::*;
#(
  parameter int N_IDS = 16,
  parameter int ID_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_IDS*FIELD_W-1:0]  fields,
  input  logic [ID_W-1:0]           id,
  output logic [IDX_W-1:0]          idx
);
  localparam int SEL_W = (N_IDS > 1) ? $clog2(N_IDS) : 1;

  logic               in_range;
  logic [SEL_W-1:0]   sel;
  logic [FIELD_W-1:0] raw;

  assign in_range = (id < ID_W'(N_IDS));
  assign sel      = in_range ? id[SEL_W-1:0] : '0;
  assign raw      = fields[int'(sel)*FIELD_W +: FIELD_W];

  always_comb begin
    if (!in_range)             idx = IDX_LAST;
    else if (raw[FIELD_W-1])   idx = IDX_LAST;
    else                       idx = raw[IDX_W-1:0];
  end

  AST_OUT_OF_RANGE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (id >= ID_W'(N_IDS)) |-> (idx == IDX_LAST)); // R7
endmodule

// File: rtl/acc_perm_lut.sv
module acc_perm_lut
  import acc_perm_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LUT_WORDS*WORD_W-1:0]   lut_flat,
  input  logic [IDX_W-1:0]              dom_idx,
  input  logic [IDX_W-1:0]              grp_idx,
  input  logic                          secure,
  output logic                          deny
);
  logic [WORD_W-1:0] word_sel;
  logic [HALF_W-1:0] half_sel;
  logic [CODE_W-1:0] code;

  assign word_sel = lut_flat[int'(grp_idx >> 1)*WORD_W +: WORD_W];
  assign half_sel = grp_idx[0] ? word_sel[WORD_W-1:HALF_W] : word_sel[HALF_W-1:0];
  assign code     = half_sel[int'(dom_idx)*CODE_W +: CODE_W];
  // high bit closes non-secure, low bit closes secure
  assign deny     = secure ? code[0] : code[1];

  AST_ZERO_WORD_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (word_sel == '0) |-> !deny); // R5
endmodule

// File: rtl/acc_perm_checker.sv
module acc_perm_checker
  import acc_perm_pkg::*;
#(
  parameter int NUM_MASTERS = 16,
  parameter int NUM_SLAVES  = 20,
  parameter int MST_ID_W    = 6,
  parameter int SLV_ID_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [MST_ID_W-1:0]  req_master,
  input  logic [SLV_ID_W-1:0]  req_slave,
  input  logic                 req_secure,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_allow
);
  logic [NUM_MASTERS*FIELD_W-1:0] dom_fields;
  logic [NUM_SLAVES*FIELD_W-1:0]  grp_fields;
  logic [LUT_WORDS*WORD_W-1:0]    lut_flat;
  logic                           bypass;
  logic [IDX_W-1:0]               dom_idx;
  logic [IDX_W-1:0]               grp_idx;
  logic                           deny;
  logic                           rsp_valid_q;
  logic                           rsp_allow_q;

  acc_cfg_regs #(.NUM_MASTERS(NUM_MASTERS), .NUM_SLAVES(NUM_SLAVES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .dom_fields(dom_fields),
    .grp_fields(grp_fields), .lut_flat(lut_flat), .bypass(bypass)
  );

  acc_id_map #(.N_IDS(NUM_MASTERS), .ID_W(MST_ID_W)) u_mst_map (
    .clk(clk), .rst_n(rst_n), .fields(dom_fields), .id(req_master), .idx(dom_idx)
  );

  acc_id_map #(.N_IDS(NUM_SLAVES), .ID_W(SLV_ID_W)) u_slv_map (
    .clk(clk), .rst_n(rst_n), .fields(grp_fields), .id(req_slave), .idx(grp_idx)
  );

  acc_perm_lut u_lut (
    .clk(clk), .rst_n(rst_n), .lut_flat(lut_flat), .dom_idx(dom_idx),
    .grp_idx(grp_idx), .secure(req_secure), .deny(deny)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_allow_q <= 1'b0;
    end else if (req_ready) begin
      rsp_valid_q <= req_valid;
      if (req_valid) rsp_allow_q <= bypass || !deny;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_allow = rsp_allow_q;

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_allow))); // R9
  AST_BYPASS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bypass) |=> (rsp_valid && rsp_allow)); // R8
endmodule

// File: tb/test_acc_perm_checker.sv
module test_acc_perm_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_master = '0;
  logic [5:0]  req_slave = '0;
  logic        req_secure = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_allow;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_perm_checker i_acc_perm_checker (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_master(req_master), .req_slave(req_slave),
    .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_allow(rsp_allow)
  );

  // {master[13:8], slave[7:2], secure[1], expected allow[0]}
  localparam int NV = 22;
  localparam logic [13:0] VEC [NV] = '{
    {6'd0,  6'd0,  1'b0, 1'b1},  // R11 d0 g0 NS
    {6'd0,  6'd0,  1'b1, 1'b1},  // R11 d0 g0 S
    {6'd3,  6'd0,  1'b0, 1'b0},  // R3 m3->d3, closed
    {6'd1,  6'd0,  1'b1, 1'b1},  // R11 d1 g0 S
    {6'd0,  6'd1,  1'b0, 1'b0},  // R5 code 10 closes NS
    {6'd0,  6'd1,  1'b1, 1'b1},  // R5 code 10 opens S
    {6'd1,  6'd1,  1'b1, 1'b0},  // R11 d1 g1 closed
    {6'd2,  6'd1,  1'b1, 1'b1},  // R11 d7 g1 S
    {6'd2,  6'd0,  1'b0, 1'b1},  // R11 d7 g0 NS
    {6'd9,  6'd0,  1'b1, 1'b0},  // R3 m9 word1 -> d2
    {6'd0,  6'd2,  1'b1, 1'b0},  // R4 s2 -> g2 closed
    {6'd2,  6'd19, 1'b0, 1'b1},  // R6 s19 field 9 -> g7, code 01 opens NS
    {6'd2,  6'd19, 1'b1, 1'b0},  // R6 code 01 closes S
    {6'd15, 6'd19, 1'b1, 1'b0},  // R6 m15 field C -> d7
    {6'd15, 6'd19, 1'b0, 1'b1},  // R6 m15 -> d7 NS
    {6'd40, 6'd0,  1'b0, 1'b1},  // R7 m40 -> d7, g0 open
    {6'd40, 6'd1,  1'b0, 1'b0},  // R7 d7 g1 NS
    {6'd40, 6'd1,  1'b1, 1'b1},  // R7 d7 g1 S
    {6'd0,  6'd50, 1'b0, 1'b0},  // R7 s50 -> g7, d0 closed
    {6'd2,  6'd50, 1'b0, 1'b1},  // R7 d7 g7 NS
    {6'd0,  6'd7,  1'b1, 1'b1},  // R4 s7 word1 -> g1
    {6'd0,  6'd12, 1'b0, 1'b1}   // R4 upper bits of word2 not decoded
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic req(input logic [5:0] m, input logic [5:0] s, input bit sec,
                     input bit exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_master = m; req_slave = s; req_secure = sec;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_allow == exp, tag, {30'd0, rsp_valid, rsp_allow}, {30'd0, 1'b1, exp});
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    rd_chk(6'd0,  32'd0, "R1 domain word 0");
    rd_chk(6'd1,  32'd0, "R1 domain word 1");
    rd_chk(6'd19, 32'd0, "R1 group word 3");
    rd_chk(6'd32, 32'd0, "R1 permission word 0");
    rd_chk(6'd48, 32'd0, "R1 control word");
    req(6'd40, 6'd50, 1'b1, 1'b1, "R1 open after reset");
    req(6'd3,  6'd2,  1'b0, 1'b1, "R1 open after reset NS");

    // configuration
    wr(6'd0,  32'h0000_3710);
    wr(6'd1,  32'hC000_0020);
    wr(6'd16, 32'h0000_0210);
    wr(6'd17, 32'h0000_0100);
    wr(6'd18, 32'hFFF0_0000);
    wr(6'd19, 32'h0009_0000);
    wr(6'd32, 32'hBFFE_3FF0);
    wr(6'd33, 32'hFFFF_FFFF);
    wr(6'd34, 32'hFFFF_FFFF);
    wr(6'd35, 32'h7FFF_FFFF);
    wr(6'd5,  32'h1234_5678);

    // R2 read back
    rd_chk(6'd0,  32'h0000_3710, "R2 domain word 0 readback");
    rd_chk(6'd1,  32'hC000_0020, "R2 domain word 1 readback");
    rd_chk(6'd18, 32'hFFF0_0000, "R2 group word 2 readback");
    rd_chk(6'd32, 32'hBFFE_3FF0, "R2 permission word 0 readback");
    rd_chk(6'd5,  32'd0,         "R2 unmapped address reads zero");

    // table of vectors (R3 R4 R5 R6 R7 R11)
    for (int i = 0; i < NV; i++)
      req(VEC[i][13:8], VEC[i][7:2], VEC[i][1], VEC[i][0], $sformatf("R5 table vector %0d", i));

    // R8 bypass
    wr(6'd48, 32'hFFFF_FFFF);
    rd_chk(6'd48, 32'd1, "R2 control reserved bits read zero");
    req(6'd0, 6'd2, 1'b1, 1'b1, "R8 bypass opens closed pair");
    req(6'd40, 6'd50, 1'b0, 1'b1, "R8 bypass opens out-of-range pair");
    wr(6'd48, 32'd0);
    req(6'd0, 6'd2, 1'b1, 1'b0, "R8 bypass cleared");

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_master = 6'd0; req_slave = 6'd0; req_secure = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_master = 6'd3;  // next request, closed pair
    #1;
    chk(rsp_valid && rsp_allow, "R9 first result present", {30'd0, rsp_valid, rsp_allow}, 32'd3);
    chk(!req_ready, "R9 ready low while stalled", {31'd0, req_ready}, 32'd0);
    repeat (2) begin
      @(negedge clk);
      #1;
      chk(rsp_valid && rsp_allow, "R9 result held while stalled", {30'd0, rsp_valid, rsp_allow}, 32'd3);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && !rsp_allow, "R9 waiting request judged after drain", {30'd0, rsp_valid, rsp_allow}, 32'd2);

    // R10 same-edge write
    @(negedge clk);
    req_valid = 1'b1; req_master = 6'd0; req_slave = 6'd0; req_secure = 1'b0;
    reg_wr_en = 1'b1; reg_addr = 6'd32; reg_wdata = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; reg_wr_en = 1'b0;
    chk(rsp_valid && rsp_allow, "R10 old table used on write edge", {30'd0, rsp_valid, rsp_allow}, 32'd3);
    req(6'd0, 6'd0, 1'b0, 1'b0, "R10 new table used afterwards");

    // R1 all-zero permission word reopens
    wr(6'd32, 32'd0);
    req(6'd3, 6'd1, 1'b1, 1'b1, "R1 zero permission word opens");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule